// File: doc/BRIEF.md
# Indirect Configuration Register Access Engine

This engine gives a host reach into configuration registers that live in several internal units, using only a small window of host registers. The host first loads a data register. It then writes a command word. The command word names the operation, the destination hop, whether the access stays on this chip or goes remote, the address space and a register offset. The engine decodes the word and runs the access on an internal request/acknowledge register bus. It then reports completion through flag bits that the host polls in the command register.

Reads end when the far side acknowledges. At that point the returned word is placed in the data register, and both the done flag and the data-ready flag rise. A circular write is issued twice: first to the local unit and then forwarded to the remote side. For PHY-space accesses, the two upper offset bits come from a separate PHY control register. If no acknowledge arrives within a parameterised window, the access is abandoned with done set and data-ready clear, and a sticky timeout bit is raised.

Host register map (word index on `host_waddr` / `host_raddr`): 0 is the data register, 1 is the command register and 2 is the PHY control register. A host read returns the selected register one clock after the index is presented.

Top module: `ind_cfg_engine`

## Requirements
- R1: After reset, the command, data and PHY control readbacks are all zero and `bus_req` is low.
- R2: A command word with sub-command field [3:0] = 0 (write) or 2 (ID-assignment request) issues exactly one bus request. That request has `bus_op` equal to the sub-command and `bus_wdata` equal to the data register. When it is acknowledged, readback bit 6 (done) becomes 1 and bit 7 (data ready) stays 0. The data register keeps its value.
- R3: Sub-command 1 (read) issues one request. Only after its acknowledge do both bit 6 and bit 7 read 1, and the data register then returns `bus_rdata`. Bit 7 is never 1 while bit 6 is 0.
- R4: `bus_space` carries command bits [23:22]. When they equal 3 (PHY space), `bus_addr` is {PHY control bits [28:27], command bits [21:16]}. For any other space value, the upper two bits of `bus_addr` are zero.
- R5: Sub-command 3 (circular write) issues two requests with the same op, hop, address and data. The first has `bus_local` = 1 and the second has `bus_local` = 0. Done rises only after the second acknowledge.
- R6: Accepting a new command clears bits 6 and 7, and both stay clear until that command finishes.
- R7: While an operation is in progress, host writes to the command or data register are ignored. No extra request is issued and the stored command is unchanged.
- R8: If a request sees no acknowledge for `TMO_CYC` cycles, the engine drops the request. Done becomes 1, data ready stays 0, the data register is unchanged, and readback bit 4 (timeout) becomes 1. Bit 4 stays set through later commands until reset.
- R9: Sub-commands 4 to 15 issue no bus request and complete with done = 1 and data ready = 0.
- R10: For sub-commands 0 to 2, `bus_hop` carries command bits [15:8] and `bus_local` carries command bit 5. All request fields stay stable while a request waits for its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_waddr | input | 2 | Host write register index |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | 2 | Host read register index |
| host_rdata | output | 32 | Registered host read data |
| bus_req | output | 1 | Internal bus request, held until acknowledge or timeout |
| bus_op | output | 4 | Sub-command of the access |
| bus_local | output | 1 | 1 for on-chip route, 0 for remote |
| bus_hop | output | 8 | Destination hop ID |
| bus_space | output | 2 | Address space select |
| bus_addr | output | 8 | Composed register offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Acknowledge from the addressed unit |
| bus_rdata | input | 32 | Read data, valid with acknowledge |

## Verification
The bench aims at a read whose data-ready flag must wait for a slow remote acknowledge. A design that raised the flag at issue would return stale data. It sends PHY-space accesses with non-zero PHY control bits. An engine that ignored the control register, or applied it to controller space, would emit a wrong offset. It checks the circular write for its second, remote leg, which a single-issue design would lose. It also sends a command during a pending access, which a careless engine would accept as a second request. Finally, it mutes the far side to force a timeout. The sticky bit must stay set and the data register must stay unchanged, where a weak design would clear the bit on the next command or capture garbage.

// File: rtl/ind_cfg_pkg.sv
package ind_cfg_pkg;
  localparam int OP_W     = 4;
  localparam int HOP_W    = 8;
  localparam int SPACE_W  = 2;
  localparam int OFS_LO_W = 6;
  localparam int OFS_HI_W = 2;
  localparam int ADDR_W   = OFS_LO_W + OFS_HI_W;

  // command word bit positions decoded by the engine
  localparam int CMD_LOCAL_BIT = 5;
  localparam int CMD_TMO_BIT   = 4;
  localparam int CMD_DONE_BIT  = 6;
  localparam int CMD_RDY_BIT   = 7;
  localparam int CMD_HOP_LSB   = 8;
  localparam int CMD_OFS_LSB   = 16;
  localparam int CMD_SPACE_LSB = 22;
  localparam int PHY_HI_LSB    = 27;

  localparam logic [OP_W-1:0]    OP_WRITE  = 4'd0;
  localparam logic [OP_W-1:0]    OP_READ   = 4'd1;
  localparam logic [OP_W-1:0]    OP_ASSIGN = 4'd2;
  localparam logic [OP_W-1:0]    OP_CIRC   = 4'd3;
  localparam logic [SPACE_W-1:0] SPACE_PHY = 2'd3;

  localparam logic [1:0] HREG_DATA = 2'd0;
  localparam logic [1:0] HREG_CMD  = 2'd1;
  localparam logic [1:0] HREG_PHY  = 2'd2;

  typedef struct packed {
    logic [OP_W-1:0]    op;
    logic               local_rt;
    logic [HOP_W-1:0]   hop;
    logic [SPACE_W-1:0] space;
    logic [ADDR_W-1:0]  addr;
    logic               known;
  } dec_t;
endpackage

// File: rtl/ind_cfg_decode.sv
module ind_cfg_decode
  import ind_cfg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   cmd,
  input  logic [OFS_HI_W-1:0] phy_hi,
  output dec_t                dec
);
  logic unused_bits;
  assign unused_bits = ^{cmd[DATA_W-1:CMD_SPACE_LSB+SPACE_W], cmd[CMD_RDY_BIT:CMD_DONE_BIT],
                         cmd[CMD_TMO_BIT]};

  always_comb begin
    dec.op       = cmd[OP_W-1:0];
    dec.local_rt = cmd[CMD_LOCAL_BIT];
    dec.hop      = cmd[CMD_HOP_LSB +: HOP_W];
    dec.space    = cmd[CMD_SPACE_LSB +: SPACE_W];
    dec.known    = (dec.op <= OP_CIRC);
    if (dec.space == SPACE_PHY)
      dec.addr = {phy_hi, cmd[CMD_OFS_LSB +: OFS_LO_W]};
    else
      dec.addr = {{OFS_HI_W{1'b0}}, cmd[CMD_OFS_LSB +: OFS_LO_W]};
  end
endmodule

// File: rtl/ind_cfg_seq.sv
module ind_cfg_seq
  import ind_cfg_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TMO_CYC = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  dec_t               dec,
  input  logic [DATA_W-1:0]  wdata,
  output logic               req,
  output logic [OP_W-1:0]    req_op,
  output logic               req_local,
  output logic [HOP_W-1:0]   req_hop,
  output logic [SPACE_W-1:0] req_space,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [DATA_W-1:0]  req_wdata,
  input  logic               ack,
  input  logic [DATA_W-1:0]  ack_rdata,
  output logic               busy,
  output logic               fin,
  output logic               fin_rd,
  output logic               fin_tmo,
  output logic [DATA_W-1:0]  fin_rdata
);
  localparam int TMO_W = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYC - 1);

  typedef enum logic {ST_IDLE, ST_REQ} st_t;
  st_t              st;
  logic             second;
  logic [TMO_W-1:0] wait_cnt;

  assign req  = (st == ST_REQ);
  assign busy = (st != ST_IDLE) || fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      second    <= 1'b0;
      wait_cnt  <= '0;
      req_op    <= '0;
      req_local <= 1'b0;
      req_hop   <= '0;
      req_space <= '0;
      req_addr  <= '0;
      req_wdata <= '0;
      fin       <= 1'b0;
      fin_rd    <= 1'b0;
      fin_tmo   <= 1'b0;
      fin_rdata <= '0;
    end else begin
      fin     <= 1'b0;
      fin_rd  <= 1'b0;
      fin_tmo <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            req_op    <= dec.op;
            req_hop   <= dec.hop;
            req_space <= dec.space;
            req_addr  <= dec.addr;
            req_wdata <= wdata;
            second    <= 1'b0;
            wait_cnt  <= '0;
            if (dec.known) begin
              st        <= ST_REQ;
              req_local <= (dec.op == OP_CIRC) ? 1'b1 : dec.local_rt;
            end else begin
              fin <= 1'b1;
            end
          end
        end
        ST_REQ: begin
          if (ack) begin
            wait_cnt <= '0;
            if (req_op == OP_CIRC && !second) begin
              second    <= 1'b1;
              req_local <= 1'b0;
            end else begin
              st        <= ST_IDLE;
              fin       <= 1'b1;
              fin_rd    <= (req_op == OP_READ);
              fin_rdata <= ack_rdata;
            end
          end else if (wait_cnt == TMO_LAST) begin
            st      <= ST_IDLE;
            fin     <= 1'b1;
            fin_tmo <= 1'b1;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ind_cfg_engine.sv
module ind_cfg_engine
  import ind_cfg_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TMO_CYC = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_we,
  input  logic [1:0]         host_waddr,
  input  logic [DATA_W-1:0]  host_wdata,
  input  logic [1:0]         host_raddr,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               bus_req,
  output logic [OP_W-1:0]    bus_op,
  output logic               bus_local,
  output logic [HOP_W-1:0]   bus_hop,
  output logic [SPACE_W-1:0] bus_space,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_ack,
  input  logic [DATA_W-1:0]  bus_rdata
);
  logic [DATA_W-1:0] data_q, cmd_q, phy_q, cmd_view;
  logic              done_q, rdy_q, tmo_q;
  logic              busy, start, fin, fin_rd, fin_tmo;
  logic [DATA_W-1:0] fin_rdata;
  dec_t              dec;

  assign start = host_we && (host_waddr == HREG_CMD) && !busy;

  ind_cfg_decode #(.DATA_W(DATA_W)) u_dec (
    .cmd    (host_wdata),
    .phy_hi (phy_q[PHY_HI_LSB +: OFS_HI_W]),
    .dec    (dec)
  );

  ind_cfg_seq #(.DATA_W(DATA_W), .TMO_CYC(TMO_CYC)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .dec       (dec),
    .wdata     (data_q),
    .req       (bus_req),
    .req_op    (bus_op),
    .req_local (bus_local),
    .req_hop   (bus_hop),
    .req_space (bus_space),
    .req_addr  (bus_addr),
    .req_wdata (bus_wdata),
    .ack       (bus_ack),
    .ack_rdata (bus_rdata),
    .busy      (busy),
    .fin       (fin),
    .fin_rd    (fin_rd),
    .fin_tmo   (fin_tmo),
    .fin_rdata (fin_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      cmd_q  <= '0;
      phy_q  <= '0;
      done_q <= 1'b0;
      rdy_q  <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      if (host_we && host_waddr == HREG_PHY)
        phy_q <= host_wdata;
      if (host_we && host_waddr == HREG_DATA && !busy)
        data_q <= host_wdata;
      else if (fin && fin_rd)
        data_q <= fin_rdata;
      if (start) begin
        cmd_q  <= host_wdata;
        done_q <= 1'b0;
        rdy_q  <= 1'b0;
      end else if (fin) begin
        done_q <= 1'b1;
        rdy_q  <= fin_rd;
      end
      if (fin_tmo)
        tmo_q <= 1'b1;
    end
  end

  always_comb begin
    cmd_view               = cmd_q;
    cmd_view[CMD_TMO_BIT]  = tmo_q;
    cmd_view[CMD_DONE_BIT] = done_q;
    cmd_view[CMD_RDY_BIT]  = rdy_q;
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else begin
      unique case (host_raddr)
        HREG_DATA: host_rdata <= data_q;
        HREG_CMD:  host_rdata <= cmd_view;
        HREG_PHY:  host_rdata <= phy_q;
        default:   host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ind_cfg_chk.sv
module ind_cfg_chk
  import ind_cfg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_ack,
  input logic [OP_W-1:0]   bus_op,
  input logic              bus_local,
  input logic [HOP_W-1:0]  bus_hop,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              busy,
  input logic              host_we,
  input logic [1:0]        host_waddr,
  input logic [DATA_W-1:0] cmd_q,
  input logic              done_q,
  input logic              rdy_q,
  input logic              tmo_q
);
  p_rdy_needs_done_r3: assert property (@(posedge clk) disable iff (rst)
    rdy_q |-> done_q);

  p_done_after_ack_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ack && !(bus_op == OP_CIRC && bus_local)) |=> ##1 done_q);

  p_circ_second_leg_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ack && bus_op == OP_CIRC && bus_local) |=> (bus_req && !bus_local && !done_q));

  p_busy_cmd_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && host_we && host_waddr == HREG_CMD) |=> $stable(cmd_q));

  p_tmo_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    tmo_q |=> tmo_q);

  p_req_fields_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> ($stable(bus_hop) && $stable(bus_addr) && $stable(bus_op)));

  p_pending_flags_clear_r6: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (!done_q && !rdy_q));
endmodule

bind ind_cfg_engine ind_cfg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_req   (bus_req),
  .bus_ack   (bus_ack),
  .bus_op    (bus_op),
  .bus_local (bus_local),
  .bus_hop   (bus_hop),
  .bus_addr  (bus_addr),
  .busy      (busy),
  .host_we   (host_we),
  .host_waddr(host_waddr),
  .cmd_q     (cmd_q),
  .done_q    (done_q),
  .rdy_q     (rdy_q),
  .tmo_q     (tmo_q)
);

// File: tb/sim_ind_cfg_engine.sv
`timescale 1ns/1ps
module sim_ind_cfg_engine;
  localparam int DW = 32;
  localparam int TMO = 64;
  localparam int LAT_LOCAL = 2;
  localparam int LAT_REMOTE = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic host_we = 1'b0;
  logic [1:0] host_waddr = '0, host_raddr = '0;
  logic [DW-1:0] host_wdata = '0, host_rdata;
  logic bus_req, bus_local, bus_ack;
  logic [3:0] bus_op;
  logic [7:0] bus_hop, bus_addr;
  logic [1:0] bus_space;
  logic [DW-1:0] bus_wdata, bus_rdata;

  always #4 clk = ~clk;

  ind_cfg_engine #(.DATA_W(DW), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst(rst), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .bus_req(bus_req), .bus_op(bus_op), .bus_local(bus_local), .bus_hop(bus_hop),
    .bus_space(bus_space), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] resp(input logic [7:0] hop, input logic [1:0] sp,
                                       input logic [7:0] ad);
    resp = 32'hA500_0000 | ({24'd0, hop} << 16) | ({30'd0, sp} << 12) | {24'd0, ad};
  endfunction

  // far-side responder model
  logic mute = 1'b0;
  int   rcnt;
  int   log_n;
  logic       lg_local [4];
  logic [3:0] lg_op    [4];
  logic [7:0] lg_hop   [4];
  logic [7:0] lg_addr  [4];
  logic [1:0] lg_space [4];
  logic [31:0] lg_wdata[4];

  always @(posedge clk) begin
    if (rst) begin
      bus_ack <= 1'b0; bus_rdata <= '0; rcnt <= 0; log_n <= 0;
    end else if (bus_ack) begin
      bus_ack <= 1'b0; rcnt <= 0;
      lg_local[log_n % 4] <= bus_local;
      lg_op[log_n % 4]    <= bus_op;
      lg_hop[log_n % 4]   <= bus_hop;
      lg_addr[log_n % 4]  <= bus_addr;
      lg_space[log_n % 4] <= bus_space;
      lg_wdata[log_n % 4] <= bus_wdata;
      log_n <= log_n + 1;
    end else if (bus_req && !mute) begin
      if (rcnt >= (bus_local ? LAT_LOCAL : LAT_REMOTE)) begin
        bus_ack   <= 1'b1;
        bus_rdata <= resp(bus_hop, bus_space, bus_addr);
      end else rcnt <= rcnt + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); host_we = 1'b1; host_waddr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic hrd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); host_raddr = a;
    @(negedge clk); d = host_rdata;
  endtask

  task automatic poll(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int k = 0; k < 300; k++) begin
      hrd(2'd1, v);
      if (v[6]) begin ok = 1; break; end
    end
  endtask

  // {command, data, phy control}
  localparam logic [95:0] VEC [6] = '{
    {32'h000D_0120, 32'h0100_8003, 32'h0000_0000},
    {32'h0005_0021, 32'h0000_0000, 32'h0000_0000},
    {32'h00E5_0201, 32'h0000_0000, 32'h1000_0000},
    {32'h0000_0123, 32'h0000_0261, 32'h0000_0000},
    {32'h0002_0002, 32'h0002_0202, 32'h0000_0000},
    {32'h00C7_0020, 32'h1234_5678, 32'h1800_0000}
  };

  initial begin
    logic [31:0] v, dsave;
    bit ok;
    int n0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    hrd(2'd1, v); chk(v == 0, "R1 cmd reset", v, 0);
    hrd(2'd0, v); chk(v == 0, "R1 data reset", v, 0);
    hrd(2'd2, v); chk(v == 0, "R1 phy reset", v, 0);
    chk(bus_req == 0, "R1 req idle", {31'd0, bus_req}, 0);

    for (int i = 0; i < 6; i++) begin
      logic [31:0] c, d, p;
      logic [3:0] op;
      logic [7:0] ea;
      int legs, li;
      c = VEC[i][95:64]; d = VEC[i][63:32]; p = VEC[i][31:0];
      op = c[3:0];
      ea = (c[23:22] == 2'd3) ? {p[28:27], c[21:16]} : {2'b00, c[21:16]};
      legs = (op == 4'd3) ? 2 : 1;
      hwr(2'd2, p);
      hwr(2'd0, d);
      n0 = log_n;
      hwr(2'd1, c);
      poll(ok);
      chk(ok, "R2 done flag raised", {31'd0, ok}, 1);
      hrd(2'd1, v);
      chk(v[7] == (op == 4'd1), "R3 data-ready flag per op", {31'd0, v[7]}, {31'd0, op == 4'd1});
      chk(log_n - n0 == legs, "R5 request count", log_n - n0, legs);
      li = (log_n - 1) % 4;
      chk(lg_addr[li] == ea, "R4 composed address", {24'd0, lg_addr[li]}, {24'd0, ea});
      chk(lg_space[li] == c[23:22], "R4 space field", {30'd0, lg_space[li]}, {30'd0, c[23:22]});
      chk(lg_op[li] == op, "R2 op forwarded", {28'd0, lg_op[li]}, {28'd0, op});
      chk(lg_hop[li] == c[15:8], "R10 hop forwarded", {24'd0, lg_hop[li]}, {24'd0, c[15:8]});
      if (op == 4'd3) begin
        chk(lg_local[n0 % 4] == 1'b1, "R5 first leg local", {31'd0, lg_local[n0 % 4]}, 1);
        chk(lg_local[li] == 1'b0, "R5 second leg remote", {31'd0, lg_local[li]}, 0);
        chk(lg_wdata[n0 % 4] == d, "R5 first leg data", lg_wdata[n0 % 4], d);
      end else begin
        chk(lg_local[li] == c[5], "R10 route forwarded", {31'd0, lg_local[li]}, {31'd0, c[5]});
      end
      hrd(2'd0, v);
      if (op == 4'd1)
        chk(v == resp(c[15:8], c[23:22], ea), "R3 read data returned", v, resp(c[15:8], c[23:22], ea));
      else begin
        chk(lg_wdata[li] == d, "R2 write data on bus", lg_wdata[li], d);
        chk(v == d, "R2 data register kept", v, d);
      end
    end

    // R6 / R7: remote read pending, host tries to overwrite command and data
    hwr(2'd2, 32'h0);
    n0 = log_n;
    hwr(2'd1, 32'h0003_0201);
    hwr(2'd1, 32'h0001_0020);
    hwr(2'd0, 32'h0000_DEAD);
    hrd(2'd1, v);
    chk(v == 32'h0003_0201, "R6 flags cleared and R7 command kept while busy", v, 32'h0003_0201);
    poll(ok);
    chk(log_n - n0 == 1, "R7 no extra request", log_n - n0, 1);
    hrd(2'd0, v);
    chk(v == resp(8'd2, 2'd0, 8'd3), "R7 data write ignored, read data kept", v, resp(8'd2, 2'd0, 8'd3));
    hrd(2'd1, v);
    chk(v[7:6] == 2'b11, "R3 both flags after read", {30'd0, v[7:6]}, 3);

    // R8 timeout
    hrd(2'd0, dsave);
    mute = 1'b1;
    hwr(2'd1, 32'h0004_0021);
    poll(ok);
    hrd(2'd1, v);
    chk(ok && v[6] && !v[7], "R8 done without ready on timeout", {30'd0, v[7:6]}, 1);
    chk(v[4] == 1'b1, "R8 timeout bit set", {31'd0, v[4]}, 1);
    hrd(2'd0, v);
    chk(v == dsave, "R8 data unchanged on timeout", v, dsave);
    mute = 1'b0;
    hwr(2'd0, 32'h55);
    hwr(2'd1, 32'h0001_0020);
    poll(ok);
    hrd(2'd1, v);
    chk(v[4] == 1'b1 && v[6], "R8 timeout bit sticky", {31'd0, v[4]}, 1);

    // R9 unsupported sub-command
    n0 = log_n;
    hwr(2'd1, 32'h0000_0025);
    poll(ok);
    hrd(2'd1, v);
    chk(ok && v[7] == 1'b0, "R9 unsupported completes without ready", {31'd0, v[7]}, 0);
    chk(log_n == n0, "R9 no bus request", log_n - n0, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule